// File: doc/BRIEF.md
# Counter-Polling Bus Arbiter

This block decides which of several devices on a shared bus may use it next, without a priority encoder. Every device pulls a common request wire when it wants the bus. When that wire is active and the bus is not already held, the channel side starts a scan. Each clock cycle it puts one device number on a narrow poll bus, stepping 1, 2, ... up to the device count and then back to 1.

Each device has a comparator cell with a fixed address. A cell that is requesting and sees its own address on the poll bus claims the bus on the next clock edge by driving the common busy wire. The channel then freezes its counter on the number that matched. The owner keeps busy high for as long as its local request stays high. When it drops the request, busy falls and the channel goes back to idle.

A mode input selects where the next scan begins. In priority mode it always begins at device 1, so lower addresses win. In round-robin mode it begins just after the last device that was served. If every request vanishes part-way through a scan, the channel returns to idle and the remembered position does not change.

Top module: `poll_arbiter`

## Requirements
- R1: `reqLine` is the OR of all bits of `devReq` in the same cycle.
- R2: A scan starts only from idle, with `reqLine` high and `busyLine` low. `pollBus` reads 0 whenever no scan is running, including every cycle in which `busyLine` is high.
- R3: During a scan, `pollBus` shows the first device number in the first cycle after the start edge. It then rises by exactly one per cycle, and after NUM_DEV it goes back to 1. Device number k (1..NUM_DEV) belongs to bit k-1 of `devReq`.
- R4: A device whose `devReq` bit is high while `pollBus` shows its number takes the bus at the next edge. `busyLine` and `ownerValid` rise in that cycle, and `ownerId` gives the owner's device number (0 when no device owns the bus). At most one device owns the bus at any time. A request that arrives at the start of a scan is therefore granted 2 + d cycles after it is applied, where d is the number of steps from the first polled number to the winner.
- R5: The counter freezes on the number that matched, not on the number after it. The owner keeps the bus while its `devReq` bit stays high, even if other devices are requesting. `busyLine` falls one cycle after that bit drops.
- R6: With `rrMode` = 0, every scan starts at device 1.
- R7: With `rrMode` = 1, a scan starts at the device after the last one granted, wrapping from NUM_DEV to 1.
- R8: If `reqLine` goes low during a scan before any match, polling stops at the next edge (`pollBus` = 0). The remembered last-served position is left unchanged.
- R9: After reset, `busyLine`, `ownerValid`, `ownerId` and `pollBus` are 0. The remembered position is NUM_DEV, so the first round-robin scan starts at device 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rrMode | input | 1 | 1 = resume after last served device, 0 = restart at device 1 |
| devReq | input | NUM_DEV | Local request of each device cell; bit k-1 is device k |
| reqLine | output | 1 | Shared request wire |
| busyLine | output | 1 | Shared busy wire, high while a device holds the bus |
| pollBus | output | $clog2(NUM_DEV+1) | Device number being polled, 0 when not scanning |
| ownerValid | output | 1 | A device holds the bus |
| ownerId | output | $clog2(NUM_DEV+1) | Device number of the owner, 0 when none |

## Verification
Two things can happen in the same cycle. The counter keeps stepping, and the registered busy wire rises one cycle after the match. The bench provokes this on every grant and judges the freeze through the next round-robin start, which must follow the granted device and not the number after it. The other overlap is a request that drops while the scan is still polling. The bench cuts all requests two cycles into a long scan. It then checks that polling stops at the next edge and that the following round-robin scan starts from the unchanged position. Every non-empty request pattern is swept in both modes, and the expected poll sequence, grant latency and owner are derived arithmetically from the start position.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } arbState_t;

  typedef struct packed {
    logic loadStart;
    logic stepCount;
    logic freeze;
  } ctrlStrobe_t;
endpackage

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqLine,
  input  logic        busyLine,
  output ctrlStrobe_t strobe,
  output logic        pollActive
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (reqLine && !busyLine) begin
        strobe.loadStart = 1'b1;
        stateNext        = ST_SCAN;
      end
      ST_SCAN: begin
        if (busyLine) begin
          strobe.freeze = 1'b1;
          stateNext     = ST_HOLD;
        end else if (!reqLine) begin
          stateNext = ST_IDLE;
        end else begin
          strobe.stepCount = 1'b1;
        end
      end
      ST_HOLD: if (!busyLine) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign pollActive = (state == ST_SCAN) && !busyLine;

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && !reqLine && !busyLine) |=> (state == ST_IDLE)); // R8
  AST_SCAN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(reqLine && !busyLine)) |=> (state == ST_IDLE)); // R2
endmodule

// File: rtl/poll_datapath.sv
module poll_datapath
  import poll_arb_pkg::*;
#(
  parameter int NUM_DEV = 4,
  localparam int PW = $clog2(NUM_DEV + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rrMode,
  input  ctrlStrobe_t   strobe,
  output logic [PW-1:0] pollCount
);
  localparam logic [PW-1:0] LAST_ADDR = PW'(NUM_DEV);
  localparam logic [PW-1:0] FIRST_ADDR = PW'(1);

  logic [PW-1:0] savedPos;
  logic [PW-1:0] startVal;
  logic [PW-1:0] countInc;
  logic [PW-1:0] countDec;

  assign countInc = (pollCount == LAST_ADDR) ? FIRST_ADDR : pollCount + FIRST_ADDR;
  assign countDec = (pollCount == FIRST_ADDR) ? LAST_ADDR : pollCount - FIRST_ADDR;
  assign startVal = rrMode ? ((savedPos == LAST_ADDR) ? FIRST_ADDR : savedPos + FIRST_ADDR)
                           : FIRST_ADDR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCount <= FIRST_ADDR;
      savedPos  <= LAST_ADDR;
    end else if (strobe.loadStart) begin
      pollCount <= startVal;
    end else if (strobe.stepCount) begin
      pollCount <= countInc;
    end else if (strobe.freeze) begin
      pollCount <= countDec;
      savedPos  <= countDec;
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (pollCount >= FIRST_ADDR) && (pollCount <= LAST_ADDR)); // R3
  AST_SAVED_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.freeze |=> $stable(savedPos)); // R8
endmodule

// File: rtl/poll_dev_cells.sv
module poll_dev_cells #(
  parameter int NUM_DEV = 4,
  localparam int PW = $clog2(NUM_DEV + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devReq,
  input  logic               pollActive,
  input  logic [PW-1:0]      pollBus,
  output logic [NUM_DEV-1:0] grantVec,
  output logic [PW-1:0]      ownerId
);
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cell
    localparam logic [PW-1:0] MY_ADDR = PW'(i + 1);
    logic hit;
    assign hit = pollActive && (pollBus == MY_ADDR) && devReq[i];
    always_ff @(posedge clk) begin
      if (!rstN)            grantVec[i] <= 1'b0;
      else if (grantVec[i]) grantVec[i] <= devReq[i];
      else                  grantVec[i] <= hit;
    end
  end

  always_comb begin
    ownerId = '0;
    for (int k = 0; k < NUM_DEV; k++)
      if (grantVec[k]) ownerId = ownerId | PW'(k + 1);
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R4
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec == '0) |=> ((grantVec & ~$past(devReq)) == '0)); // R4
  AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ((grantVec & devReq) != '0) |=> (grantVec == $past(grantVec))); // R5
endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter
  import poll_arb_pkg::*;
#(
  parameter int NUM_DEV = 4,
  localparam int PW = $clog2(NUM_DEV + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rrMode,
  input  logic [NUM_DEV-1:0] devReq,
  output logic               reqLine,
  output logic               busyLine,
  output logic [PW-1:0]      pollBus,
  output logic               ownerValid,
  output logic [PW-1:0]      ownerId
);
  ctrlStrobe_t        strobe;
  logic               pollActive;
  logic [PW-1:0]      pollCount;
  logic [NUM_DEV-1:0] grantVec;

  assign reqLine    = |devReq;
  assign busyLine   = |grantVec;
  assign ownerValid = busyLine;
  assign pollBus    = pollActive ? pollCount : '0;

  poll_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqLine(reqLine), .busyLine(busyLine),
    .strobe(strobe), .pollActive(pollActive)
  );

  poll_datapath #(.NUM_DEV(NUM_DEV)) u_dp (
    .clk(clk), .rstN(rstN), .rrMode(rrMode), .strobe(strobe), .pollCount(pollCount)
  );

  poll_dev_cells #(.NUM_DEV(NUM_DEV)) u_cells (
    .clk(clk), .rstN(rstN), .devReq(devReq), .pollActive(pollActive),
    .pollBus(pollBus), .grantVec(grantVec), .ownerId(ownerId)
  );

  AST_BUSY_NO_POLL: assert property (@(posedge clk) disable iff (!rstN)
    busyLine |-> (pollBus == '0)); // R2
  AST_FREEZE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyLine) |=> (pollCount == ownerId)); // R5
  AST_PRIO_START: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadStart && !rrMode) |=> (pollBus == PW'(1))); // R6
  AST_DROP_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !reqLine |=> (pollBus == '0)); // R8
endmodule

// File: tb/poll_arbiter_bench.sv
module poll_arbiter_bench;
  localparam int N  = 5;
  localparam int PW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rrMode = 1'b0;
  logic [N-1:0]  devReq = '0;
  logic          reqLine, busyLine, ownerValid;
  logic [PW-1:0] pollBus, ownerId;

  int checks = 0;
  int fails  = 0;
  int lastServed = N;
  bit done = 1'b0;

  always #10 clk = ~clk;

  poll_arbiter #(.NUM_DEV(N)) u_poll_arbiter (
    .clk(clk), .rstN(rstN), .rrMode(rrMode), .devReq(devReq),
    .reqLine(reqLine), .busyLine(busyLine), .pollBus(pollBus),
    .ownerValid(ownerValid), .ownerId(ownerId)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wrapAddr(input int a);
    return ((a - 1) % N) + 1;
  endfunction

  task automatic trial(input bit mode, input logic [N-1:0] vec);
    int s, w, d, j;
    s = mode ? wrapAddr(lastServed + 1) : 1;
    w = 0;
    for (int k = 0; k < N && w == 0; k++)
      if (vec[wrapAddr(s + k) - 1]) w = wrapAddr(s + k);
    d = (w - s + N) % N;
    @(negedge clk);
    rrMode = mode;
    devReq = vec;
    #1 chk("R1 reqLine", reqLine, 1);
    j = 0;
    while (j < N + 4) begin
      @(negedge clk);
      j++;
      if (busyLine) break;
      chk(mode ? "R3/R7 poll" : "R3/R6 poll", pollBus, wrapAddr(s + j - 1));
    end
    chk("R4 grant latency", j, d + 2);
    chk("R4 ownerId", ownerId, w);
    chk("R4 ownerValid", ownerValid, 1);
    chk("R2 poll idle while busy", pollBus, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R5 owner held", ownerId, w);
    devReq = '0;
    @(negedge clk);
    chk("R5 busy falls", busyLine, 0);
    @(negedge clk);
    @(negedge clk);
    lastServed = w;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 busy reset", busyLine, 0);
    chk("R9 owner reset", ownerValid, 0);
    chk("R9 ownerId reset", ownerId, 0);
    chk("R9 poll reset", pollBus, 0);
    chk("R1 reqLine low", reqLine, 0);
    rstN = 1'b1;
    // R9: first round-robin scan starts at device 1, tested via device 3 alone
    trial(1'b1, N'(5'b00100));
    for (int pass = 0; pass < 2; pass++)
      for (int m = 0; m < 2; m++)
        for (int v = 1; v < (1 << N); v++)
          trial(m[0], N'(v));
    // R8: drop requests mid-scan; saved position must stay put
    begin
      int s0, far;
      s0  = wrapAddr(lastServed + 1);
      far = wrapAddr(s0 + 3);
      @(negedge clk);
      rrMode = 1'b1;
      devReq = '0;
      devReq[far - 1] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R8 scanning", pollBus, wrapAddr(s0 + 1));
      devReq = '0;
      @(negedge clk);
      chk("R8 poll stops", pollBus, 0);
      chk("R8 no owner", busyLine, 0);
      @(negedge clk);
      chk("R2 no scan without req", pollBus, 0);
      trial(1'b1, N'(1) << (s0 - 1)); // R8: starts again at s0, zero steps
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule